// File: doc/BRIEF.md
# Tree Reduction Sum Sequencer

This block takes a set of partial sums, one per lane, and folds them into one total through a series of halving steps. It is for the final stage of a parallel sum, after each worker has produced its own partial result. A start strobe loads all lanes at once from a wide parallel bus. The block then runs one halving step per clock. In each step, every lane below the current dividing line adds in the lane that sits one dividing-line distance above it. When the dividing line is odd, lane 0 also takes in the unpaired top element. The lane count therefore does not have to be a power of two.

Every addition in a step reads the lane values as they stood at the start of that step, and all the results are written on the same edge. Each step is a barrier: no lane moves to the next step before the whole step is complete. When the dividing line reaches 1, lane 0 holds the total. The block then registers the total, pulses a done flag and returns to idle. The total and the step count stay on the outputs until the next accepted start.

Top module: `tree_reduce_sum`

## Requirements
- R1: When `start` is high at a clock edge while `busy` is low, all LANES values on `load_bus` are captured (lane i from bits [i*WIDTH +: WIDTH]), `busy` is high after that edge and `step_cnt` is 0.
- R2: While `busy` is high, exactly one halving step happens per clock, and `step_cnt` rises by one at every edge where `busy` was high.
- R3: A run takes floor(log2(LANES)) steps, because the dividing line goes from LANES to LANES/2 with integer division until it reaches 1 (100 gives 100, 50, 25, 12, 6, 3, 1: six steps; 7 gives two steps; 2 gives one step; 128 gives seven steps).
- R4: At the end of a run, `total` equals the sum of all LANES loaded values modulo 2^WIDTH. This holds for odd and non-power-of-two lane counts, where lane 0 folds in element (dividing line − 1) at every odd step.
- R5: `done` is high for exactly one cycle, in the cycle right after the final step edge. `busy` is low in that cycle, and `total` already holds the result.
- R6: A `start` that arrives while `busy` is high is ignored. The run in progress keeps its step count and its result.
- R7: While idle, `total` and `step_cnt` stay unchanged until the next accepted start, whatever `load_bus` does.
- R8: After a synchronous reset (`rst` high at a clock edge), `busy` and `done` are low and `total` and `step_cnt` are 0.
- R9: A `start` given in the cycle where `done` is high is accepted at once, so runs can follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the lanes and begin a run (used only when idle) |
| load_bus | input | LANES*WIDTH | Initial partial sums, lane i at bits [i*WIDTH +: WIDTH] |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last step |
| total | output | WIDTH | Final sum, held until the next accepted start |
| step_cnt | output | $clog2(LANES) | Steps completed in the current or last run |

## Verification
A wrong lane pairing, or an odd leftover that is dropped or counted twice, shows only in `total`, and only when `done` pulses, several cycles after the fault. For this reason the bench loads data patterns in which every lane's value changes the sum: ascending values, all ones for wrap-around, and random data, run at odd, even, power-of-two and non-power-of-two lane counts. A wrong divider or a wrong stop condition shows sooner, in `step_cnt` and in the cycle where `done` rises. Both are compared at every clock against a behavioural model, so a run that is one step long or short is flagged in the same cycle.

// File: rtl/trs_pkg.sv
package trs_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } trs_state_e;

  // Number of halvings that take n down to 1.
  function automatic int halvings(input int n);
    int d;
    int s;
    d = n;
    s = 0;
    while (d > 1) begin
      d = d / 2;
      s = s + 1;
    end
    return s;
  endfunction

endpackage

// File: rtl/trs_ctrl.sv
module trs_ctrl #(
  parameter int LANES = 100,
  localparam int IW = $clog2(LANES + 1),
  localparam int SW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          load_en,
  output logic          step_en,
  output logic          last_step,
  output logic [IW-1:0] dline,
  output logic [SW-1:0] step_cnt
);
  import trs_pkg::*;

  trs_state_e    state_q;
  logic [IW-1:0] dline_q;
  logic [IW-1:0] half;
  logic [SW-1:0] cnt_q;
  logic          done_q;

  assign half      = dline_q >> 1;
  assign load_en   = (state_q == ST_IDLE) && start;
  assign step_en   = (state_q == ST_RUN);
  assign last_step = step_en && (half == IW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      dline_q <= IW'(LANES);
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_step;
      if (load_en) begin
        state_q <= ST_RUN;
        dline_q <= IW'(LANES);
        cnt_q   <= '0;
      end else if (step_en) begin
        dline_q <= half;
        cnt_q   <= cnt_q + SW'(1);
        if (last_step) state_q <= ST_IDLE;
      end
    end
  end

  assign busy     = (state_q == ST_RUN);
  assign done     = done_q;
  assign dline    = dline_q;
  assign step_cnt = cnt_q;

endmodule

// File: rtl/trs_lane_bank.sv
module trs_lane_bank #(
  parameter int LANES = 100,
  parameter int WIDTH = 32,
  localparam int IW = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_en,
  input  logic                   step_en,
  input  logic [IW-1:0]          dline,
  input  logic [LANES*WIDTH-1:0] load_bus,
  output logic [WIDTH-1:0]       lane0_next
);

  logic [WIDTH-1:0] lanes [LANES];
  logic [WIDTH-1:0] nxt   [LANES];
  logic [IW-1:0]    half;

  assign half = dline >> 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IW-1:0]    pidx;
    logic [WIDTH-1:0] partner;
    logic [WIDTH-1:0] leftover;

    assign pidx = IW'(g) + half;

    always_comb begin
      partner = '0;
      if (IW'(g) < half) partner = lanes[pidx];
    end

    if (g == 0) begin : g_fold
      // Unpaired top element when the dividing line is odd.
      always_comb begin
        leftover = '0;
        if (dline[0] && (dline > IW'(1))) leftover = lanes[dline - IW'(1)];
      end
    end else begin : g_plain
      assign leftover = '0;
    end

    assign nxt[g] = lanes[g] + partner + leftover;

    always_ff @(posedge clk) begin
      if (rst) begin
        lanes[g] <= '0;
      end else if (load_en) begin
        lanes[g] <= load_bus[g*WIDTH +: WIDTH];
      end else if (step_en) begin
        lanes[g] <= nxt[g];
      end
    end
  end

  assign lane0_next = nxt[0];

endmodule

// File: rtl/tree_reduce_sum.sv
module tree_reduce_sum #(
  parameter int LANES = 100,
  parameter int WIDTH = 32,
  localparam int IW = $clog2(LANES + 1),
  localparam int SW = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [LANES*WIDTH-1:0] load_bus,
  output logic                   busy,
  output logic                   done,
  output logic [WIDTH-1:0]       total,
  output logic [SW-1:0]          step_cnt
);

  logic          load_en;
  logic          step_en;
  logic          last_step;
  logic [IW-1:0] dline;
  logic [WIDTH-1:0] lane0_next;
  logic [WIDTH-1:0] total_q;

  trs_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .done(done), .load_en(load_en), .step_en(step_en),
    .last_step(last_step), .dline(dline), .step_cnt(step_cnt)
  );

  trs_lane_bank #(.LANES(LANES), .WIDTH(WIDTH)) u_bank (
    .clk(clk), .rst(rst), .load_en(load_en), .step_en(step_en),
    .dline(dline), .load_bus(load_bus), .lane0_next(lane0_next)
  );

  always_ff @(posedge clk) begin
    if (rst)            total_q <= '0;
    else if (last_step) total_q <= lane0_next;
  end

  assign total = total_q;

endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
  parameter int LANES = 100,
  parameter int WIDTH = 32,
  localparam int IW = $clog2(LANES + 1),
  localparam int SW = $clog2(LANES),
  localparam int MAXST = trs_pkg::halvings(LANES)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [WIDTH-1:0] total,
  input logic [SW-1:0] step_cnt,
  input logic [IW-1:0] dline
);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && step_cnt == '0)); // R1

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    busy |=> (step_cnt == $past(step_cnt) + SW'(1))); // R2

  AST_DLINE_HALVES: assert property (@(posedge clk) disable iff (rst)
    busy |=> (dline == ($past(dline) >> 1))); // R3

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (int'(step_cnt) <= MAXST)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R5

  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (step_cnt != '0)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(total) && $stable(step_cnt))); // R7

endmodule

bind tree_reduce_sum trs_checker #(.LANES(LANES), .WIDTH(WIDTH)) u_trs_checker (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .total(total), .step_cnt(step_cnt), .dline(dline)
);

// File: tb/test_tree_reduce_sum.sv
module trs_harness #(
  parameter int LANES = 100,
  parameter int WIDTH = 32,
  localparam int SW = $clog2(LANES)
) (
  input logic clk,
  input logic rst
);

  logic                   start;
  logic [LANES*WIDTH-1:0] load_bus;
  logic                   busy;
  logic                   done;
  logic [WIDTH-1:0]       total;
  logic [SW-1:0]          step_cnt;

  int  vectors = 0;
  int  misses  = 0;
  bit  finished = 0;

  tree_reduce_sum #(.LANES(LANES), .WIDTH(WIDTH)) i_tree_reduce_sum (
    .clk(clk), .rst(rst), .start(start), .load_bus(load_bus),
    .busy(busy), .done(done), .total(total), .step_cnt(step_cnt)
  );

  function automatic int exp_steps();
    int d = LANES;
    int s = 0;
    while (d > 1) begin d = d / 2; s++; end
    return s;
  endfunction

  function automatic logic [WIDTH-1:0] seq_sum(input logic [LANES*WIDTH-1:0] b);
    logic [WIDTH-1:0] acc = '0;
    for (int i = 0; i < LANES; i++) acc = acc + b[i*WIDTH +: WIDTH];
    return acc;
  endfunction

  // Behavioural reference model, advanced on every clock
  bit               m_busy, m_done, armed;
  int               m_left, m_steps;
  logic [WIDTH-1:0] m_total, m_pend;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_left = 0; m_steps = 0; m_total = '0;
      armed = 1;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_steps++;
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_total = m_pend;
        end
      end else if (start) begin
        m_busy = 1; m_steps = 0; m_left = exp_steps(); m_pend = seq_sum(load_bus);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s lanes=%0d actual=%0d expected=%0d", tag, LANES, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk(busy == m_busy, "R1 busy", busy, m_busy);
      chk(done == m_done, "R5 done", done, m_done);
      chk(int'(step_cnt) == m_steps, "R2 step_cnt", step_cnt, m_steps);
      chk(total == m_total, "R4 total", total, m_total);
    end
  end

  task automatic fill(input int kind);
    for (int i = 0; i < LANES; i++)
      case (kind)
        0: load_bus[i*WIDTH +: WIDTH] = '0;
        1: load_bus[i*WIDTH +: WIDTH] = '1;
        2: load_bus[i*WIDTH +: WIDTH] = WIDTH'(i + 1);
        default: load_bus[i*WIDTH +: WIDTH] = WIDTH'($urandom);
      endcase
  endtask

  // One run; poke drives a stray start during the run.
  task automatic job(input int kind, input bit poke);
    logic [WIDTH-1:0] exp;
    fill(kind);
    exp = seq_sum(load_bus);
    start = 1;
    @(negedge clk);
    chk(busy && step_cnt == '0, "R1 accept", busy, 1);
    start = poke;
    if (poke) fill(3);
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk(total == exp, "R4 final sum", total, exp);
    chk(int'(step_cnt) == exp_steps(), "R3 step count", step_cnt, exp_steps());
    if (poke) chk(total == exp, "R6 stray start ignored", total, exp);
    @(negedge clk);
    chk(!done, "R5 done one cycle", done, 0);
  endtask

  initial begin
    logic [WIDTH-1:0] held;
    start = 0;
    load_bus = '0;
    @(negedge clk);
    while (rst) @(negedge clk);
    chk(!busy && !done && total == '0 && step_cnt == '0, "R8 reset state", total, 0);
    job(2, 0);
    job(1, 0);
    job(0, 0);
    for (int k = 0; k < 6; k++) job(3, k[0]);
    // R7: idle hold against bus changes
    held = total;
    fill(3);
    repeat (4) @(negedge clk);
    chk(total == held, "R7 idle total held", total, held);
    chk(int'(step_cnt) == exp_steps(), "R7 idle step_cnt held", step_cnt, exp_steps());
    // R9: back-to-back start in the done cycle
    fill(2);
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    fill(3);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && step_cnt == '0, "R9 back-to-back accept", busy, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
    finished = 1;
  end

endmodule

module test_tree_reduce_sum;

  logic clk = 0;
  logic rst = 1;
  int   cycles = 0;
  int   wd_fail = 0;

  always #5 clk = ~clk;

  trs_harness #(.LANES(100)) h_even   (.clk(clk), .rst(rst));
  trs_harness #(.LANES(7))   h_odd    (.clk(clk), .rst(rst));
  trs_harness #(.LANES(2))   h_min    (.clk(clk), .rst(rst));
  trs_harness #(.LANES(128)) h_pow2   (.clk(clk), .rst(rst));

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
  end

  always @(posedge clk) cycles++;

  initial begin
    while (!(h_even.finished && h_odd.finished && h_min.finished && h_pow2.finished)
           && cycles < 150000)
      @(negedge clk);
    if (cycles >= 150000) begin
      wd_fail = 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==",
             h_even.vectors + h_odd.vectors + h_min.vectors + h_pow2.vectors + wd_fail,
             h_even.misses + h_odd.misses + h_min.misses + h_pow2.misses + wd_fail);
    $finish;
  end

endmodule